// File: doc/BRIEF.md
# Legacy Real-Mode Memory Region Decoder

This block sits between an emulated real-mode CPU bus and the memories behind it. It takes a 20-bit physical address and sends it to one of four backing targets: a shadow store for option-ROM code, a video-memory store, main RAM, or a small built-in identification table at the very top of the map. A request carries a size of one, two or four bytes. Multi-byte data is little-endian. Each accepted request is answered on the following clock edge.

Two address ranges need special handling. The first is the stretch between the end of the programmed ROM window and the next 64 KiB boundary. An access there is flagged as suspect and redirected to the first RAM byte. The second is any address past the configured RAM limit that no other window claims. An access there raises a halt flag and is also redirected to RAM byte zero. When video emulation is switched on, the video window behaves as a sink: reads return zero and writes are dropped.

Each backing store is an internal byte array whose depth is a power of two. A store is indexed by the window offset modulo its depth, so a small store aliases across a large window.

Top module: `legacy_mem_map`

## Requirements
- R1: After reset `ack`, `rdata`, `suspect` and `halt` are 0. A request (`req`=1) at a clock edge gives `ack`=1 with that request's results after the edge. A cycle without a request gives `ack`=0, `rdata`=0, `suspect`=0 and `halt`=0 after the edge.
- R2: With `rom_limit` held in 0xC0000..0xCFFFF, addresses from 0xC0000 to `rom_limit` inclusive reach the ROM store at offset (address − 0xC0000). This window is checked before every other window.
- R3: Addresses above `rom_limit` and below 0xD0000 set `suspect` with the ack. Reads and writes there go to RAM byte 0 onward.
- R4: Addresses 0xA0000..0xBFFFF reach the video store at offset (address − 0xA0000) while `vga_emu`=0.
- R5: While `vga_emu`=1, reads in 0xA0000..0xBFFFF return 0 and writes there leave the video store unchanged.
- R6: The identification table covers 0xFFFF5..0xFFFFF. The ASCII date "08/14/99" occupies 0xFFFF5..0xFFFFC, a zero byte sits at 0xFFFFD, the model byte 0xFC at 0xFFFFE and the submodel byte 0x00 at 0xFFFFF. Byte lanes that fall past 0xFFFFF read 0. Writes to the table have no effect.
- R7: Any other address greater than `ram_limit` sets `halt` with the ack and is redirected to RAM byte 0 onward.
- R8: All remaining addresses reach RAM at offset equal to the address.
- R9: Size encoding: `size`=00 is a byte, 01 is a word, 10 and 11 are a dword. Byte k of the access (address offset k) travels on `rdata`/`wdata` bits [8k+7:8k]. Read lanes beyond the size return 0, and a write touches only the bytes within its size.
- R10: Each store is indexed by (offset + k) modulo its depth. A multi-byte access therefore wraps inside the store and does not cross into another target.
- R11: A write is acknowledged with `rdata`=0, and `suspect`/`halt` are reported as they would be for a read of the same address.

Port widths below use the default parameters; the data and address widths are fixed by the legacy map.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_limit | input | 20 | Last byte address of the ROM window |
| ram_limit | input | 20 | Highest valid RAM address |
| vga_emu | input | 1 | Video window acts as a zero-read, write-drop sink |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Access size (see R9) |
| addr | input | 20 | Byte address of lane 0 |
| wdata | input | 32 | Write data, little-endian lanes |
| ack | output | 1 | Access completed (cycle after `req`) |
| rdata | output | 32 | Read data, little-endian lanes |
| suspect | output | 1 | Access landed in the gap after the ROM window |
| halt | output | 1 | Access exceeded the RAM limit |

## Verification
The suspect gap is the hardest case to reach. It exists only when `rom_limit` sits below 0xCFFFF, and its redirect is visible only if RAM byte 0 holds a known, distinct value. The stimulus therefore re-draws `rom_limit` inside the 64 KiB ROM segment every couple of hundred accesses. It biases addresses into that segment, and it checks gap writes by reading RAM byte 0 back directly. Multi-byte accesses that straddle a store's wrap point, or the tail of the identification table, are also aimed at explicitly.

// File: rtl/lmm_pkg.sv
// Shared constants and types for the legacy memory map decoder.
// Assumes a 20-bit real-mode physical address space.
package lmm_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    localparam logic [ADDR_W-1:0] VID_BASE = 20'hA0000;
    localparam logic [ADDR_W-1:0] VID_LAST = 20'hBFFFF;
    localparam logic [ADDR_W-1:0] ROM_BASE = 20'hC0000;
    localparam logic [ADDR_W-1:0] GAP_END  = 20'hD0000;
    localparam logic [ADDR_W-1:0] ID_BASE  = 20'hFFFF5;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;

    typedef enum logic [1:0] {
        TGT_RAM = 2'd0,
        TGT_ROM = 2'd1,
        TGT_VID = 2'd2,
        TGT_ID  = 2'd3
    } tgt_e;
endpackage

// File: rtl/lmm_region_decode.sv
// Priority address decoder: picks the target, the offset into it and the
// suspect/halt/blank qualifiers. Purely combinational.
// Assumes rom_limit lies within the 64 KiB ROM segment.
module lmm_region_decode
    import lmm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] rom_limit,
    input  logic [ADDR_W-1:0] ram_limit,
    input  logic              vga_emu,
    output tgt_e              tgt,
    output logic [ADDR_W-1:0] off,
    output logic              suspect,
    output logic              halt,
    output logic              blank
);
    // Windows tested in fixed priority: ROM, gap, video, ID, RAM limit.
    always_comb begin
        tgt     = TGT_RAM;
        off     = addr;
        suspect = 1'b0;
        halt    = 1'b0;
        blank   = 1'b0;
        if (addr >= ROM_BASE && addr <= rom_limit) begin
            tgt = TGT_ROM;
            off = addr - ROM_BASE;
        end else if (addr > rom_limit && addr < GAP_END) begin
            off     = '0;
            suspect = 1'b1;
        end else if (addr >= VID_BASE && addr <= VID_LAST) begin
            tgt   = TGT_VID;
            off   = addr - VID_BASE;
            blank = vga_emu;
        end else if (addr >= ID_BASE) begin
            tgt = TGT_ID;
            off = addr - ID_BASE;
        end else if (addr > ram_limit) begin
            off  = '0;
            halt = 1'b1;
        end
    end
endmodule

// File: rtl/lmm_byte_store.sv
// Byte-wide storage array with a four-lane little-endian port.
// Lane k reads/writes entry (off + k) mod DEPTH. DEPTH must be a power of two.
// Reads are combinational; writes land on the clock edge.
module lmm_byte_store
    import lmm_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_en,
    input  logic [ADDR_W-1:0] off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] idx [LANES];

    // Wrapped entry index for each lane.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            idx[k] = AW'((off + ADDR_W'(k)) % ADDR_W'(DEPTH));
        end
    end

    // Read lanes in parallel.
    for (genvar g = 0; g < LANES; g++) begin : g_rd
        assign rdata[8*g +: 8] = mem[idx[g]];
    end

    // Write enabled lanes.
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (wr_en && lane_en[k]) begin
                mem[idx[k]] <= wdata[8*k +: 8];
            end
        end
    end
endmodule

// File: rtl/lmm_id_table.sv
// Read-only identification bytes at the top of the map: eight date
// characters, a zero terminator, the model byte and the submodel byte.
// Lanes beyond the table read zero.
module lmm_id_table
    import lmm_pkg::*;
#(
    parameter logic [63:0] DATE     = "08/14/99",
    parameter logic [7:0]  MODEL    = 8'hFC,
    parameter logic [7:0]  SUBMODEL = 8'h00
) (
    input  logic [ADDR_W-1:0] off,
    output logic [DATA_W-1:0] rdata
);
    function automatic logic [7:0] id_byte(input logic [ADDR_W:0] j);
        logic [63:0] sh;
        sh = DATE >> (8 * (7 - int'(j[2:0])));
        if (j < 8)       return sh[7:0];
        else if (j == 9) return MODEL;
        else if (j == 10) return SUBMODEL;
        else             return 8'h00;
    endfunction

    // Look up one table byte per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rdata[8*g +: 8] = id_byte({1'b0, off} + (ADDR_W+1)'(g));
    end
endmodule

// File: rtl/legacy_mem_map.sv
// Top of the legacy memory map decoder. Decodes each request, reads or
// writes the selected store and registers the response for one cycle.
// Assumes one request per cycle at most and rom_limit in the ROM segment.
module legacy_mem_map
    import lmm_pkg::*;
#(
    parameter int          RAM_DEPTH   = 1024,
    parameter int          VID_DEPTH   = 256,
    parameter int          ROM_DEPTH   = 256,
    parameter logic [63:0] ID_DATE     = "08/14/99",
    parameter logic [7:0]  ID_MODEL    = 8'hFC,
    parameter logic [7:0]  ID_SUBMODEL = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [19:0]       rom_limit,
    input  logic [19:0]       ram_limit,
    input  logic              vga_emu,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [19:0]       addr,
    input  logic [31:0]       wdata,
    output logic              ack,
    output logic [31:0]       rdata,
    output logic              suspect,
    output logic              halt
);
    tgt_e              tgt;
    logic [ADDR_W-1:0] off;
    logic              dec_suspect, dec_halt, dec_blank;
    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] ram_rd, vid_rd, rom_rd, id_rd, sel_rd, rd_next;
    logic              wr;

    lmm_region_decode u_dec (
        .addr      (addr),
        .rom_limit (rom_limit),
        .ram_limit (ram_limit),
        .vga_emu   (vga_emu),
        .tgt       (tgt),
        .off       (off),
        .suspect   (dec_suspect),
        .halt      (dec_halt),
        .blank     (dec_blank)
    );

    assign wr = req && we;

    // Lanes covered by the access size.
    always_comb begin
        case (size)
            SZ_BYTE: lane_en = 4'b0001;
            SZ_WORD: lane_en = 4'b0011;
            default: lane_en = 4'b1111;
        endcase
    end

    lmm_byte_store #(.DEPTH(RAM_DEPTH)) u_ram (
        .clk     (clk),
        .wr_en   (wr && tgt == TGT_RAM),
        .lane_en (lane_en),
        .off     (off),
        .wdata   (wdata),
        .rdata   (ram_rd)
    );

    lmm_byte_store #(.DEPTH(VID_DEPTH)) u_vid (
        .clk     (clk),
        .wr_en   (wr && tgt == TGT_VID && !dec_blank),
        .lane_en (lane_en),
        .off     (off),
        .wdata   (wdata),
        .rdata   (vid_rd)
    );

    lmm_byte_store #(.DEPTH(ROM_DEPTH)) u_rom (
        .clk     (clk),
        .wr_en   (wr && tgt == TGT_ROM),
        .lane_en (lane_en),
        .off     (off),
        .wdata   (wdata),
        .rdata   (rom_rd)
    );

    lmm_id_table #(
        .DATE     (ID_DATE),
        .MODEL    (ID_MODEL),
        .SUBMODEL (ID_SUBMODEL)
    ) u_id (
        .off   (off),
        .rdata (id_rd)
    );

    // Select the target's data, then apply blanking and lane masking.
    always_comb begin
        case (tgt)
            TGT_ROM: sel_rd = rom_rd;
            TGT_VID: sel_rd = dec_blank ? '0 : vid_rd;
            TGT_ID:  sel_rd = id_rd;
            default: sel_rd = ram_rd;
        endcase
        for (int k = 0; k < LANES; k++) begin
            rd_next[8*k +: 8] = (lane_en[k] && !we) ? sel_rd[8*k +: 8] : 8'h00;
        end
    end

    // Response register: one-cycle ack carrying data and qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack     <= 1'b0;
            rdata   <= '0;
            suspect <= 1'b0;
            halt    <= 1'b0;
        end else begin
            ack     <= req;
            rdata   <= req ? rd_next : '0;
            suspect <= req && dec_suspect;
            halt    <= req && dec_halt;
        end
    end
endmodule

// File: rtl/legacy_mem_map_chk.sv
// Property checker for legacy_mem_map, attached by bind below.
module legacy_mem_map_chk #(
    parameter logic [7:0] MODEL = 8'hFC
) (
    input logic        clk,
    input logic        rst_n,
    input logic [19:0] rom_limit,
    input logic [19:0] ram_limit,
    input logic        vga_emu,
    input logic        req,
    input logic        we,
    input logic [1:0]  size,
    input logic [19:0] addr,
    input logic        ack,
    input logic [31:0] rdata,
    input logic        suspect,
    input logic        halt
);
    a_r1_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ack);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!ack && !suspect && !halt && rdata == 32'h0));
    a_r3_gap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req && addr >= 20'hC0000 && addr > rom_limit && addr < 20'hD0000)
        |=> (suspect && !halt));
    a_r5_blank_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && vga_emu && addr >= 20'hA0000 && addr <= 20'hBFFFF)
        |=> (rdata == 32'h0));
    a_r6_model_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && size == 2'b00 && addr == 20'hFFFFE)
        |=> (rdata == {24'h0, MODEL}));
    a_r7_halt_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req && addr > ram_limit && addr < 20'hA0000 && rom_limit >= 20'hBFFFF)
        |=> (halt && !suspect));
    a_r9_byte_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && size == 2'b00) |=> (rdata[31:8] == 24'h0));
    a_r11_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we) |=> (rdata == 32'h0));
endmodule

bind legacy_mem_map legacy_mem_map_chk #(.MODEL(ID_MODEL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rom_limit (rom_limit),
    .ram_limit (ram_limit),
    .vga_emu   (vga_emu),
    .req       (req),
    .we        (we),
    .size      (size),
    .addr      (addr),
    .ack       (ack),
    .rdata     (rdata),
    .suspect   (suspect),
    .halt      (halt)
);

// File: tb/legacy_mem_map_test.sv
`timescale 1ns/1ps
module legacy_mem_map_test;
    localparam int RAMD = 1024;
    localparam int VIDD = 256;
    localparam int ROMD = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] rom_limit = 20'hCFFFF;
    logic [19:0] ram_limit = 20'h9FFFF;
    logic        vga_emu = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  size = 2'b00;
    logic [19:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        ack, suspect, halt;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_ram [RAMD];
    logic [7:0] m_vid [VIDD];
    logic [7:0] m_rom [ROMD];

    always #2 clk = ~clk;

    legacy_mem_map uut (
        .clk(clk), .rst_n(rst_n), .rom_limit(rom_limit), .ram_limit(ram_limit),
        .vga_emu(vga_emu), .req(req), .we(we), .size(size), .addr(addr),
        .wdata(wdata), .ack(ack), .rdata(rdata), .suspect(suspect), .halt(halt)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Region code: 0 RAM, 1 ROM, 2 gap, 3 video, 4 ID, 5 over-limit.
    function automatic int region_of(input logic [19:0] a);
        if (a >= 20'hC0000 && a <= rom_limit) return 1;
        if (a > rom_limit && a < 20'hD0000)   return 2;
        if (a >= 20'hA0000 && a <= 20'hBFFFF) return 3;
        if (a >= 20'hFFFF5)                   return 4;
        if (a > ram_limit)                    return 5;
        return 0;
    endfunction

    function automatic logic [7:0] id_byte(input int j);
        string d;
        d = "08/14/99";
        if (j < 8) return d[j];
        if (j == 9) return 8'hFC;
        return 8'h00;
    endfunction

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_read(input logic [19:0] a, input logic [1:0] s);
        logic [31:0] v;
        int r;
        v = '0;
        r = region_of(a);
        for (int k = 0; k < nbytes(s); k++) begin
            case (r)
                1: v[8*k +: 8] = m_rom[(int'(a - 20'hC0000) + k) % ROMD];
                2, 5: v[8*k +: 8] = m_ram[k % RAMD];
                3: v[8*k +: 8] = vga_emu ? 8'h00 : m_vid[(int'(a - 20'hA0000) + k) % VIDD];
                4: v[8*k +: 8] = id_byte(int'(a - 20'hFFFF5) + k);
                default: v[8*k +: 8] = m_ram[(int'(a) + k) % RAMD];
            endcase
        end
        return v;
    endfunction

    function automatic void model_write(input logic [19:0] a, input logic [1:0] s,
                                        input logic [31:0] d);
        int r;
        r = region_of(a);
        for (int k = 0; k < nbytes(s); k++) begin
            case (r)
                1: m_rom[(int'(a - 20'hC0000) + k) % ROMD] = d[8*k +: 8];
                2, 5: m_ram[k % RAMD] = d[8*k +: 8];
                3: if (!vga_emu) m_vid[(int'(a - 20'hA0000) + k) % VIDD] = d[8*k +: 8];
                4: ;
                default: m_ram[(int'(a) + k) % RAMD] = d[8*k +: 8];
            endcase
        end
    endfunction

    function automatic string tag_of(input logic [19:0] a);
        case (region_of(a))
            1: return "R2";
            2: return "R3";
            3: return vga_emu ? "R5" : "R4";
            4: return "R6";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    // One access: drive at negedge, sample results at the next negedge.
    task automatic access(input logic w, input logic [1:0] s, input logic [19:0] a,
                          input logic [31:0] d, input string tag_in);
        logic [31:0] e;
        logic        es, eh;
        string       tag;
        tag = (tag_in == "") ? tag_of(a) : tag_in;
        e  = w ? 32'h0 : exp_read(a, s);
        es = (region_of(a) == 2);
        eh = (region_of(a) == 5);
        req = 1'b1; we = w; size = s; addr = a; wdata = d;
        @(negedge clk);
        check(tag, "ack", {31'h0, ack}, 32'h1);
        check(tag, "rdata", rdata, e);
        check(tag, "suspect", {31'h0, suspect}, {31'h0, es});
        check(tag, "halt", {31'h0, halt}, {31'h0, eh});
        if (w) model_write(a, s, d);
        req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "reset ack", {31'h0, ack}, 32'h0);
        check("R1", "reset rdata", rdata, 32'h0);
        check("R1", "reset flags", {30'h0, suspect, halt}, 32'h0);

        // Fill every store through the ports (R8, R4, R2).
        for (int i = 0; i < RAMD; i += 4) access(1'b1, 2'b10, 20'(i), $urandom, "R8");
        for (int i = 0; i < VIDD; i += 4) access(1'b1, 2'b10, 20'hA0000 + 20'(i), $urandom, "R4");
        for (int i = 0; i < ROMD; i += 4) access(1'b1, 2'b10, 20'hC0000 + 20'(i), $urandom, "R2");

        // R1: idle cycle leaves outputs quiet
        @(negedge clk);
        check("R1", "idle ack", {31'h0, ack}, 32'h0);
        check("R1", "idle rdata", rdata, 32'h0);

        // R9: little-endian lanes and partial writes
        access(1'b1, 2'b10, 20'h00010, 32'h44332211, "R9");
        access(1'b0, 2'b00, 20'h00011, 0, "R9");
        access(1'b0, 2'b01, 20'h00012, 0, "R9");
        access(1'b1, 2'b00, 20'h00011, 32'hDEADBEAA, "R9");
        access(1'b0, 2'b11, 20'h00010, 0, "R9");
        check("R9", "partial byte write", m_ram[16 + 1], 8'hAA);
        check("R9", "neighbour untouched", {24'h0, m_ram[16 + 2]}, 32'h33);
        // R10: wrap inside stores
        access(1'b0, 2'b10, 20'h003FE, 0, "R10");
        access(1'b0, 2'b10, 20'hA00FE, 0, "R10");
        access(1'b0, 2'b10, 20'hA1000, 0, "R10");
        // R2 / R3: ROM window and gap
        rom_limit = 20'hC7FFF;
        access(1'b0, 2'b10, 20'hC0100, 0, "R2");
        access(1'b0, 2'b10, 20'hC7FFF, 0, "R2");
        access(1'b0, 2'b10, 20'hC8000, 0, "R3");
        access(1'b1, 2'b01, 20'hCFFFF, 32'h0000BEEF, "R3");
        access(1'b0, 2'b01, 20'h00000, 0, "R3");
        // R5: emulated video sink
        access(1'b1, 2'b10, 20'hA0010, 32'h12345678, "R4");
        vga_emu = 1'b1;
        access(1'b1, 2'b10, 20'hA0010, 32'hCAFEF00D, "R5");
        access(1'b0, 2'b10, 20'hA0010, 0, "R5");
        vga_emu = 1'b0;
        access(1'b0, 2'b10, 20'hA0010, 0, "R5");
        // R6: identification table
        for (int i = 0; i < 11; i++) access(1'b0, 2'b00, 20'hFFFF5 + 20'(i), 0, "R6");
        access(1'b0, 2'b10, 20'hFFFFC, 0, "R6");
        access(1'b0, 2'b10, 20'hFFFFE, 0, "R6");
        access(1'b1, 2'b00, 20'hFFFFE, 32'h11, "R6");
        access(1'b0, 2'b00, 20'hFFFFE, 0, "R6");
        // R7: over-limit halt
        ram_limit = 20'h003FF;
        access(1'b0, 2'b10, 20'h00500, 0, "R7");
        access(1'b0, 2'b10, 20'hD0000, 0, "R7");
        access(1'b1, 2'b00, 20'h9FFFF, 32'h5A, "R7");
        access(1'b0, 2'b00, 20'h00000, 0, "R7");
        // R11: write ack with flags
        access(1'b1, 2'b10, 20'hC9000, 32'hFFFFFFFF, "R11");

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [19:0] a;
            int sel;
            if (n % 200 == 0) begin
                rom_limit = 20'hC0000 + 20'($urandom % 20'h10000);
                ram_limit = ($urandom % 4 == 0) ? 20'hFFFFF : 20'h00100 + 20'($urandom % 20'h800);
                vga_emu = ($urandom % 3 == 0);
            end
            sel = $urandom % 8;
            case (sel)
                0: a = 20'hC0000 + 20'($urandom % 20'h10000);
                1: a = 20'hA0000 + 20'($urandom % 20'h20000);
                2: a = 20'hFFFF0 + 20'($urandom % 16);
                3: a = ram_limit - 20'd2 + 20'($urandom % 5);
                4: a = rom_limit - 20'd2 + 20'($urandom % 5);
                5: a = 20'($urandom);
                default: a = 20'($urandom % 20'h800);
            endcase
            access($urandom % 3 == 0, 2'($urandom), a, $urandom, "");
            if ($urandom % 16 == 0) begin
                @(negedge clk);
                check("R1", "idle ack", {31'h0, ack}, 32'h0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule